// File: doc/BRIEF.md
# Flash Programming Sequencer

This block sits on the host side of a parallel NOR flash device and writes a run of words into it. Software, or a neighbouring block, supplies a base address, a word count and a choice between the standard programming flow and the faster bypass flow. It then pulses start. For each word the sequencer presents an index on its source port and takes back an address offset and a data word. It then drives the flash command cycles for that word on a simple asynchronous bus and polls the device status until the word has finished or has failed.

In the fast flow the device is switched once into bypass mode before the first word. Each word then costs two write cycles instead of four, and the device is switched back to normal before the run ends. When a word fails, the sequencer stops the run. It returns the device to read mode, leaves bypass mode if that mode was in use, and reports the failing address. Every run, whether it passes or fails, ends with a single-cycle done pulse.

Top module: `flash_prog_seq`

## Requirements
- R1: With fast_sel high at start, the run opens with three write cycles before any word: address 0x555 data 0xAA, then 0x2AA / 0x55, then 0x555 / 0x20.
- R2: In normal mode each word takes four write cycles: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the word address with the word data.
- R3: In fast mode each word takes two write cycles: 0x555/0xA0, then the word address with the word data.
- R4: Words are fetched by driving src_idx 0, 1, … word_count-1 in turn. Word i is written at base_addr + src_off, with no ordering required between the offsets.
- R5: After a word's data cycle the sequencer reads the word address. Bit 7 of the read value equal to bit 7 of the word data completes the word. A mismatch with bit 5 clear causes another read.
- R6: A status read with a bit 7 mismatch and bit 5 set ends the run without writing further words. The sequencer writes 0xF0 at address 0 and, in fast mode, then issues the bypass exit of R7. error is raised and err_addr holds the failing word address.
- R7: In fast mode, after the last word completes, two write cycles at address 0 (data 0x90, then 0x00) are issued before done.
- R8: Every bus cycle holds fl_ce_n low together with exactly one of fl_we_n or fl_oe_n for exactly PULSE clocks. fl_addr stays stable throughout.
- R9: busy is high from the clock after an accepted start until the clock after done. done is high for exactly one clock at the end of every run. error stays valid until the next accepted start.
- R10: start is ignored while busy is high.
- R11: A word_count of zero ends the run with no bus cycle in normal mode, and with only the bypass entry and exit in fast mode.
- R12: After reset, fl_ce_n, fl_we_n and fl_oe_n are high and busy, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| fast_sel | input | 1 | 1 = bypass flow, 0 = standard flow |
| base_addr | input | AW | Address added to every word offset |
| word_count | input | CW | Number of words in the run |
| src_idx | output | CW | Index of the word being fetched |
| src_off | input | AW | Address offset of word src_idx |
| src_data | input | DW | Data of word src_idx |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | DW | Data read from the flash |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| error | output | 1 | Last run ended on a failed word |
| err_addr | output | AW | Address of the failed word |

## Verification
The assertions assume that fl_dq_in is stable during the last clock of each read strobe. They also assume that src_off and src_data follow src_idx without delay and stay fixed while a word is being handled. The bench meets both conditions with a flash model that changes its status value only at falling clock edges, after a strobe has ended. It serves the source port from a fixed table indexed combinationally by src_idx. Every status sequence the model produces, whether an immediate match, several mismatching reads or a failure flag, is one the sequencer is specified to handle.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ENTRY,
    PH_PROG,
    PH_POLL,
    PH_RDRST,
    PH_EXIT,
    PH_DONE
  } phase_e;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_WRITE  = 8'hA0;
  localparam logic [7:0] CMD_FASTON = 8'h20;
  localparam logic [7:0] CMD_FOFF1  = 8'h90;
  localparam logic [7:0] CMD_FOFF2  = 8'h00;
  localparam logic [7:0] CMD_READ   = 8'hF0;

  localparam logic [11:0] KEY_ADDR1 = 12'h555;
  localparam logic [11:0] KEY_ADDR2 = 12'h2AA;

  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_FAIL_BIT = 5;

endpackage

// File: rtl/fps_bus_cycle.sv
module fps_bus_cycle #(
  parameter int AW    = 22,
  parameter int DW    = 16,
  parameter int PULSE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          ready,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_drive,
  input  logic [DW-1:0] bus_din
);

  localparam int PW = (PULSE < 2) ? 1 : $clog2(PULSE);

  typedef enum logic [1:0] {B_IDLE, B_ACT, B_REC} bst_e;

  bst_e          st_q, st_n;
  logic [PW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q, rd_q;
  logic          wr_q;
  logic          take_en, samp_en;

  assign take_en = (st_q == B_IDLE) && go;
  assign samp_en = (st_q == B_ACT) && (cnt_q == '0) && !wr_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      B_IDLE: if (go) begin
        st_n  = B_ACT;
        cnt_n = PW'(PULSE - 1);
      end
      B_ACT: begin
        if (cnt_q == '0) st_n = B_REC;
        else             cnt_n = cnt_q - PW'(1);
      end
      default: st_n = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
      a_q   <= '0;
      d_q   <= '0;
      wr_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      if (take_en) begin
        a_q  <= addr_i;
        d_q  <= data_i;
        wr_q <= wr;
      end
      if (samp_en) rd_q <= bus_din;
    end
  end

  assign ready     = (st_q == B_IDLE);
  assign ack       = (st_q == B_REC);
  assign rdata     = rd_q;
  assign bus_ce_n  = (st_q != B_ACT);
  assign bus_we_n  = !((st_q == B_ACT) && wr_q);
  assign bus_oe_n  = !((st_q == B_ACT) && !wr_q);
  assign bus_addr  = a_q;
  assign bus_dout  = d_q;
  assign bus_drive = (st_q != B_IDLE) && wr_q;

endmodule

// File: rtl/fps_cmd_sel.sv
module fps_cmd_sel
  import fps_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  phase_e        phase,
  input  logic [1:0]    step,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data,
  output logic          c_write
);

  function automatic logic [DW-1:0] widen(input logic [7:0] b);
    return DW'(b);
  endfunction

  always_comb begin
    c_addr  = '0;
    c_data  = '0;
    c_write = 1'b1;
    case (phase)
      PH_ENTRY, PH_PROG: begin
        case (step)
          2'd0: begin c_addr = AW'(KEY_ADDR1); c_data = widen(CMD_KEY1); end
          2'd1: begin c_addr = AW'(KEY_ADDR2); c_data = widen(CMD_KEY2); end
          2'd2: begin
            c_addr = AW'(KEY_ADDR1);
            c_data = widen((phase == PH_ENTRY) ? CMD_FASTON : CMD_WRITE);
          end
          default: begin c_addr = waddr; c_data = wdata; end
        endcase
      end
      PH_POLL: begin
        c_addr  = waddr;
        c_write = 1'b0;
      end
      PH_RDRST: c_data = widen(CMD_READ);
      PH_EXIT:  c_data = widen((step == 2'd0) ? CMD_FOFF1 : CMD_FOFF2);
      default: ;
    endcase
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW    = 22,
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int PULSE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fast_sel,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] word_count,
  output logic [CW-1:0] src_idx,
  input  logic [AW-1:0] src_off,
  input  logic [DW-1:0] src_data,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] err_addr
);

  phase_e        ph_q, ph_n;
  logic [1:0]    step_q, step_n;
  logic [CW-1:0] idx_q, idx_n, cnt_q, cnt_n;
  logic [AW-1:0] base_q, base_n, eaddr_q, eaddr_n;
  logic          fast_q, fast_n, err_q, err_n, wait_q, wait_n;

  logic          bus_ph, go, ready, ack, c_write;
  logic [AW-1:0] waddr, c_addr;
  logic [DW-1:0] c_data, rdata;
  logic          word_ok, word_bad, last_word;
  logic [DW-1:0] unused_rd;

  assign waddr     = base_q + src_off;
  assign bus_ph    = (ph_q inside {PH_ENTRY, PH_PROG, PH_POLL, PH_RDRST, PH_EXIT});
  assign go        = bus_ph && !wait_q && ready;
  assign word_ok   = rdata[STAT_DONE_BIT] == src_data[STAT_DONE_BIT];
  assign word_bad  = !word_ok && rdata[STAT_FAIL_BIT];
  assign last_word = (idx_q == cnt_q - CW'(1));
  assign unused_rd = rdata;

  fps_cmd_sel #(.AW(AW), .DW(DW)) u_cmd (
    .phase(ph_q), .step(step_q), .waddr(waddr), .wdata(src_data),
    .c_addr(c_addr), .c_data(c_data), .c_write(c_write)
  );

  fps_bus_cycle #(.AW(AW), .DW(DW), .PULSE(PULSE)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(go), .wr(c_write),
    .addr_i(c_addr), .data_i(c_data), .ready(ready), .ack(ack), .rdata(rdata),
    .bus_ce_n(fl_ce_n), .bus_we_n(fl_we_n), .bus_oe_n(fl_oe_n),
    .bus_addr(fl_addr), .bus_dout(fl_dq_out), .bus_drive(fl_dq_oe),
    .bus_din(fl_dq_in)
  );

  always_comb begin
    ph_n    = ph_q;
    step_n  = step_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    base_n  = base_q;
    eaddr_n = eaddr_q;
    fast_n  = fast_q;
    err_n   = err_q;
    wait_n  = wait_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        fast_n = fast_sel;
        base_n = base_addr;
        cnt_n  = word_count;
        idx_n  = '0;
        err_n  = 1'b0;
        step_n = 2'd0;
        if (fast_sel)               ph_n = PH_ENTRY;
        else if (word_count == '0)  ph_n = PH_DONE;
        else                        ph_n = PH_PROG;
      end
      PH_DONE: ph_n = PH_IDLE;
      default: begin
        if (go) wait_n = 1'b1;
        if (ack) begin
          wait_n = 1'b0;
          step_n = step_q + 2'd1;
          case (ph_q)
            PH_ENTRY: if (step_q == 2'd2) begin
              ph_n   = (cnt_q == '0) ? PH_EXIT : PH_PROG;
              step_n = (cnt_q == '0) ? 2'd0 : 2'd2;
            end
            PH_PROG: if (step_q == 2'd3) ph_n = PH_POLL;
            PH_POLL: begin
              step_n = 2'd0;
              if (word_ok) begin
                if (last_word) ph_n = fast_q ? PH_EXIT : PH_DONE;
                else begin
                  idx_n  = idx_q + CW'(1);
                  ph_n   = PH_PROG;
                  step_n = fast_q ? 2'd2 : 2'd0;
                end
              end else if (word_bad) begin
                eaddr_n = waddr;
                ph_n    = PH_RDRST;
              end
            end
            PH_RDRST: begin
              err_n  = 1'b1;
              step_n = 2'd0;
              ph_n   = fast_q ? PH_EXIT : PH_DONE;
            end
            default: if (step_q == 2'd1) ph_n = PH_DONE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      step_q  <= 2'd0;
      idx_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      eaddr_q <= '0;
      fast_q  <= 1'b0;
      err_q   <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      step_q  <= step_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      base_q  <= base_n;
      eaddr_q <= eaddr_n;
      fast_q  <= fast_n;
      err_q   <= err_n;
      wait_q  <= wait_n;
    end
  end

  assign src_idx  = idx_q;
  assign busy     = (ph_q != PH_IDLE);
  assign done     = (ph_q == PH_DONE);
  assign error    = err_q;
  assign err_addr = eaddr_q;

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int AW    = 22,
  parameter int PULSE = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic [AW-1:0] fl_addr,
  input logic          busy,
  input logic          done,
  input logic          error
);

  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_cnt <= '0;
    else if (!fl_we_n) lo_cnt <= lo_cnt + 16'd1;
    else               lo_cnt <= '0;
  end

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  p_strobe_in_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

  p_write_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (lo_cnt == 16'(PULSE)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_done_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_error_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (busy && fl_ce_n));

endmodule

bind flash_prog_seq fps_checker #(.AW(AW), .PULSE(PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
  .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .busy(busy), .done(done),
  .error(error)
);

// File: tb/tb_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_flash_prog_seq;

  localparam int AW = 22, DW = 16, CW = 8, PULSE = 3;

  logic          clk, rst_n, start, fast_sel;
  logic [AW-1:0] base_addr, src_off, fl_addr, err_addr;
  logic [CW-1:0] word_count, src_idx;
  logic [DW-1:0] src_data, fl_dq_out, fl_dq_in;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, busy, done, error;

  flash_prog_seq #(.AW(AW), .DW(DW), .CW(CW), .PULSE(PULSE)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [DW-1:0] data_mem [16];
  logic [AW-1:0] off_mem  [16];
  assign src_data = data_mem[src_idx[3:0]];
  assign src_off  = off_mem[src_idx[3:0]];

  logic [AW-1:0] wlog_a [64], exp_a [64];
  logic [DW-1:0] wlog_d [64], exp_d [64];
  int wn, en, rn, rd_since, busy_n, we_lo;
  bit err_en;
  logic [AW-1:0] err_wa, last_wa;
  logic [DW-1:0] last_wd;
  logic prev_we, prev_oe;

  always @(negedge clk) begin
    if (!fl_we_n) we_lo++;
    if (prev_we === 1'b0 && fl_we_n === 1'b1) begin
      chk(we_lo == PULSE, "R8", "write strobe width", we_lo, PULSE);
      if (wn < 64) begin wlog_a[wn] = fl_addr; wlog_d[wn] = fl_dq_out; end
      wn++;
      last_wa = fl_addr; last_wd = fl_dq_out; rd_since = 0; we_lo = 0;
    end
    if (prev_oe === 1'b0 && fl_oe_n === 1'b1) begin rn++; rd_since++; end
    prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  always_comb begin
    fl_dq_in = last_wd;
    if (err_en && last_wa == err_wa) begin
      fl_dq_in[7] = ~last_wd[7]; fl_dq_in[5] = 1'b1;
    end else if (rd_since < busy_n) begin
      fl_dq_in[7] = ~last_wd[7]; fl_dq_in[5] = 1'b0;
    end
  end

  task automatic push(logic [AW-1:0] a, logic [DW-1:0] d);
    exp_a[en] = a; exp_d[en] = d; en++;
  endtask

  task automatic run_case(string req, bit fast, int cnt, logic [AW-1:0] base,
                          int bn, int eidx, bit poke);
    int t;
    en = 0; wn = 0; rn = 0; we_lo = 0; busy_n = bn;
    last_wa = '1; last_wd = '0;
    err_en = (eidx >= 0);
    err_wa = err_en ? base + off_mem[eidx] : '0;
    if (fast) begin push(22'h555, 16'hAA); push(22'h2AA, 16'h55); push(22'h555, 16'h20); end
    for (int i = 0; i < cnt; i++) begin
      if (!fast) begin push(22'h555, 16'hAA); push(22'h2AA, 16'h55); end
      push(22'h555, 16'hA0);
      push(base + off_mem[i], data_mem[i]);
      if (i == eidx) break;
    end
    if (err_en) push(22'h0, 16'hF0);
    if (fast) begin push(22'h0, 16'h90); push(22'h0, 16'h00); end
    @(negedge clk);
    start = 1'b1; fast_sel = fast; base_addr = base; word_count = CW'(cnt);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", {req, " busy after start"}, busy, 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      start = 1'b1; fast_sel = ~fast; base_addr = 22'h3F0000; word_count = 8'd1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R9", {req, " done reached"}, done, 1);
    chk(error == err_en, "R6", {req, " error flag"}, error, err_en);
    if (err_en) chk(err_addr == err_wa, "R6", {req, " err_addr"}, err_addr, err_wa);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", {req, " done one cycle"}, {done, busy}, 0);
    chk(error == err_en, "R9", {req, " error held"}, error, err_en);
    chk(wn == en, req, {req, " write count"}, wn, en);
    for (int i = 0; i < en && i < wn; i++) begin
      if (wlog_a[i] != exp_a[i] || wlog_d[i] != exp_d[i]) begin
        chk(0, req, $sformatf("%s write %0d addr/data", req, i),
            {wlog_a[i], wlog_d[i]}, {exp_a[i], exp_d[i]});
        break;
      end
    end
    chk(1, req, "sequence", 0, 0);
    if (!err_en) chk(rn == cnt * (bn + 1), "R5", {req, " status reads"}, rn, cnt * (bn + 1));
  endtask

  task automatic t_reset();
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R12", "strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    chk(!busy && !done && !error, "R12", "flags low", {busy, done, error}, 0);
  endtask

  task automatic t_normal();     run_case("R2", 1'b0, 3, 22'h010000, 0, -1, 1'b0); endtask
  task automatic t_fast();       run_case("R3", 1'b1, 4, 22'h200000, 2, -1, 1'b0); endtask
  task automatic t_poll_wait();  run_case("R5", 1'b0, 2, 22'h001000, 3, -1, 1'b0); endtask
  task automatic t_err_normal(); run_case("R6", 1'b0, 4, 22'h030000, 1, 2, 1'b0); endtask
  task automatic t_err_fast();   run_case("R6", 1'b1, 3, 22'h100000, 0, 0, 1'b0); endtask
  task automatic t_zero();
    run_case("R11", 1'b0, 0, 22'h0, 0, -1, 1'b0);
    run_case("R11", 1'b1, 0, 22'h0, 0, -1, 1'b0);
  endtask
  task automatic t_busy_start(); run_case("R10", 1'b0, 3, 22'h004000, 1, -1, 1'b1); endtask
  task automatic t_order();      run_case("R4", 1'b1, 6, 22'h2F0000, 0, -1, 1'b0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      data_mem[i] = DW'(16'h1234 * (i + 3) ^ (i[0] ? 16'h0080 : 16'h0000));
      off_mem[i]  = AW'(((i * 7) % 16) * 16'h0101 + 3);
    end
    start = 1'b0; fast_sel = 1'b0; base_addr = '0; word_count = '0;
    busy_n = 0; err_en = 0; err_wa = '0; last_wa = '1; last_wd = '0;
    wn = 0; rn = 0; rd_since = 0; we_lo = 0; prev_we = 1'b1; prev_oe = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_fast();
    t_poll_wait();
    t_err_normal();
    t_err_fast();
    t_zero();
    t_busy_start();
    t_order();
    // R1 and R7 are covered by the fast-mode sequences above
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule